// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Alarm

This block is a real-time clock core. It advances on a one-second tick enable, which is generated outside the block. Seconds, minutes and hours are kept as packed BCD bytes. A binary day counter sits next to them. An alarm compares the minute, hour and day of the running time against programmed values. Each of those three fields can be enabled on its own. A match sets a sticky flag, and the flag can drive an interrupt line.

Software uses a byte-addressed register port. A write lands on the clock edge when `reg_we` is high. Read data is combinational from `reg_addr`. Before each access, software polls the busy bit in the control register. Busy is high only in a cycle where a tick advances the counters, and any write made in such a cycle is dropped. The port is a plain register port with no handshake. The one stall is busy, which software observes by reading.

Top module: `bcd_tod_alarm`

## Requirements
- R1: Reset clears the time, the day, the alarm compare values and every control bit. While reset is held, every mapped register reads 0x00 and `alarm_irq` is low.
- R2: Seconds are packed BCD at byte address 0x15. On each counting tick, seconds step 00..59. From 59 they return to 00 and the minute is carried.
- R3: Minutes are BCD at 0x16 and run 59→00, carrying into the hour. Hours are BCD at 0x17 and run 23→00, carrying into the day.
- R4: The day is a DAY_W-bit (default 15) binary count. Its low byte reads at 0x18 and its upper bits at 0x19, with unused high bits reading 0. The count wraps from all ones to 0.
- R5: The counters advance only on a tick while control bit 0 (run) is 1. With run at 0, a tick changes nothing.
- R6: Control register 0x14 has this layout: bit7 busy (read-only), bit5 day-compare enable, bit4 hour-compare enable, bit3 minute-compare enable, bit2 alarm flag, bit1 interrupt enable, bit0 run. Bit6 reads 0. Busy reads 1 exactly in a cycle where `tick` and run are both 1.
- R7: A write presented in a busy cycle is ignored, whatever its address.
- R8: The alarm compare registers are: minute 0x1A (BCD), hour 0x1B (BCD), day low 0x1C, day high 0x1D. Each register reads back the value written. Any address outside 0x14..0x1D reads 0x00.
- R9: The alarm flag is set on the tick where seconds roll from 59 to 00, if every enabled field of the updated time equals its compare value. Fields that are not enabled are not compared.
- R10: When none of the three compare enables is set, the alarm flag is never set.
- R11: Writing control with bit2 = 1 clears the alarm flag. Writing bit2 = 0 leaves the flag unchanged.
- R12: `alarm_irq` is high exactly while the alarm flag and the interrupt enable (bit1) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
The bench builds the block with the default DAY_W of 15, so the day high register has the full seven-bit width. The day wrap from 0x7FFF and the chained rollover from 23:59:59 are brought within reach by preloading the counters through the register port, not by waiting out real ticks. The tick is applied on single cycles, so busy cycles can be aimed at chosen writes. Each compare enable is tested alone and in combination, which shows that disabled fields do not take part in the match.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Byte addresses of the register file
  localparam logic [7:0] ADR_CTRL    = 8'h14;
  localparam logic [7:0] ADR_SEC     = 8'h15;
  localparam logic [7:0] ADR_MIN     = 8'h16;
  localparam logic [7:0] ADR_HOUR    = 8'h17;
  localparam logic [7:0] ADR_DAY_LO  = 8'h18;
  localparam logic [7:0] ADR_DAY_HI  = 8'h19;
  localparam logic [7:0] ADR_CMP_MIN = 8'h1A;
  localparam logic [7:0] ADR_CMP_HR  = 8'h1B;
  localparam logic [7:0] ADR_CMP_DLO = 8'h1C;
  localparam logic [7:0] ADR_CMP_DHI = 8'h1D;

  // Control bit positions
  localparam int CB_BUSY   = 7;
  localparam int CB_DAY_EN = 5;
  localparam int CB_HR_EN  = 4;
  localparam int CB_MIN_EN = 3;
  localparam int CB_FLAG   = 2;
  localparam int CB_IRQ_EN = 1;
  localparam int CB_RUN    = 0;

  typedef struct packed {
    logic day_en;
    logic hr_en;
    logic min_en;
    logic irq_en;
    logic run;
  } tod_cfg_t;
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] LIMIT = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] value,
  output logic [7:0] next_value,
  output logic       wrap
);
  always_comb begin
    if (value == LIMIT)
      next_value = 8'h00;
    else if (value[3:0] == 4'd9)
      next_value = {value[7:4] + 4'd1, 4'h0};
    else
      next_value = {value[7:4], value[3:0] + 4'd1};
  end

  assign wrap = step && (value == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      value <= 8'h00;
    else if (load)
      value <= load_val;
    else if (step)
      value <= next_value;
  end

  // R2/R3: a field at its limit returns to zero on a step
  a_r2_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && value == LIMIT) |=> (value == 8'h00));

  // R5: without step or load the field holds
  a_r5_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(value));
endmodule

// File: rtl/rtc_day_count.sv
module rtc_day_count #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_lo,
  input  logic             load_hi,
  input  logic [7:0]       load_val,
  output logic [DAY_W-1:0] value
);
  localparam int HI_W = DAY_W - 8;

  always_ff @(posedge clk) begin
    if (!rst_n)
      value <= '0;
    else if (step)
      value <= value + 1'b1;
    else begin
      if (load_lo) value[7:0] <= load_val;
      if (load_hi) value[DAY_W-1:8] <= load_val[HI_W-1:0];
    end
  end

  // R4: the day count wraps from all ones to zero
  a_r4_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && value == {DAY_W{1'b1}}) |=> (value == '0));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_min,
  input  logic             we_hr,
  input  logic             we_dlo,
  input  logic             we_dhi,
  input  logic [7:0]       wdata,
  input  tod_cfg_t         cfg,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hr,
  input  logic [DAY_W-1:0] cur_day,
  output logic [7:0]       cmp_min,
  output logic [7:0]       cmp_hr,
  output logic [DAY_W-1:0] cmp_day,
  output logic             hit
);
  localparam int HI_W = DAY_W - 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_min <= 8'h00;
      cmp_hr  <= 8'h00;
      cmp_day <= '0;
    end else begin
      if (we_min) cmp_min <= wdata;
      if (we_hr)  cmp_hr  <= wdata;
      if (we_dlo) cmp_day[7:0] <= wdata;
      if (we_dhi) cmp_day[DAY_W-1:8] <= wdata[HI_W-1:0];
    end
  end

  logic any_en, min_ok, hr_ok, day_ok;
  always_comb begin
    any_en = cfg.min_en | cfg.hr_en | cfg.day_en;
    min_ok = !cfg.min_en || (cur_min == cmp_min);
    hr_ok  = !cfg.hr_en  || (cur_hr  == cmp_hr);
    day_ok = !cfg.day_en || (cur_day == cmp_day);
    hit    = any_en && min_ok && hr_ok && day_ok;
  end

  // R8: compare values change only through a write
  a_r8_cmp_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_min || we_hr || we_dlo || we_dhi) |=>
      ($stable(cmp_min) && $stable(cmp_hr) && $stable(cmp_day)));
endmodule

// File: rtl/bcd_tod_alarm.sv
module bcd_tod_alarm
  import rtc_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       alarm_irq
);
  tod_cfg_t cfg;
  logic flag;
  logic busy, wr_ok;
  logic [7:0] sec_v, min_v, hr_v, sec_n, min_n, hr_n;
  logic sec_wrap, min_wrap, hr_wrap;
  logic [DAY_W-1:0] day_v, cmp_day;
  logic [7:0] cmp_min, cmp_hr;
  logic hit;
  logic [7:0] upd_min, upd_hr;
  logic [DAY_W-1:0] upd_day;

  assign busy  = tick && cfg.run;
  assign wr_ok = reg_we && !busy;

  function automatic logic wsel(input logic ok, input logic [7:0] a, input logic [7:0] t);
    return ok && (a == t);
  endfunction

  rtc_bcd_field #(.LIMIT(8'h59)) u_sec (
    .clk(clk), .rst_n(rst_n), .step(busy), .load(wsel(wr_ok, reg_addr, ADR_SEC)),
    .load_val(reg_wdata), .value(sec_v), .next_value(sec_n), .wrap(sec_wrap));

  rtc_bcd_field #(.LIMIT(8'h59)) u_min (
    .clk(clk), .rst_n(rst_n), .step(sec_wrap), .load(wsel(wr_ok, reg_addr, ADR_MIN)),
    .load_val(reg_wdata), .value(min_v), .next_value(min_n), .wrap(min_wrap));

  rtc_bcd_field #(.LIMIT(8'h23)) u_hr (
    .clk(clk), .rst_n(rst_n), .step(min_wrap), .load(wsel(wr_ok, reg_addr, ADR_HOUR)),
    .load_val(reg_wdata), .value(hr_v), .next_value(hr_n), .wrap(hr_wrap));

  rtc_day_count #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst_n(rst_n), .step(hr_wrap),
    .load_lo(wsel(wr_ok, reg_addr, ADR_DAY_LO)), .load_hi(wsel(wr_ok, reg_addr, ADR_DAY_HI)),
    .load_val(reg_wdata), .value(day_v));

  // Values the counters take after this tick, used for the alarm compare
  always_comb begin
    upd_min = sec_wrap ? min_n : min_v;
    upd_hr  = min_wrap ? hr_n  : hr_v;
    upd_day = hr_wrap  ? day_v + 1'b1 : day_v;
  end

  rtc_alarm_match #(.DAY_W(DAY_W)) u_alm (
    .clk(clk), .rst_n(rst_n),
    .we_min(wsel(wr_ok, reg_addr, ADR_CMP_MIN)), .we_hr(wsel(wr_ok, reg_addr, ADR_CMP_HR)),
    .we_dlo(wsel(wr_ok, reg_addr, ADR_CMP_DLO)), .we_dhi(wsel(wr_ok, reg_addr, ADR_CMP_DHI)),
    .wdata(reg_wdata), .cfg(cfg), .cur_min(upd_min), .cur_hr(upd_hr), .cur_day(upd_day),
    .cmp_min(cmp_min), .cmp_hr(cmp_hr), .cmp_day(cmp_day), .hit(hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      flag <= 1'b0;
    end else if (wsel(wr_ok, reg_addr, ADR_CTRL)) begin
      cfg.day_en <= reg_wdata[CB_DAY_EN];
      cfg.hr_en  <= reg_wdata[CB_HR_EN];
      cfg.min_en <= reg_wdata[CB_MIN_EN];
      cfg.irq_en <= reg_wdata[CB_IRQ_EN];
      cfg.run    <= reg_wdata[CB_RUN];
      if (reg_wdata[CB_FLAG]) flag <= 1'b0;
    end else if (sec_wrap && hit) begin
      flag <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_CTRL:    reg_rdata = {busy, 1'b0, cfg.day_en, cfg.hr_en, cfg.min_en,
                                flag, cfg.irq_en, cfg.run};
      ADR_SEC:     reg_rdata = sec_v;
      ADR_MIN:     reg_rdata = min_v;
      ADR_HOUR:    reg_rdata = hr_v;
      ADR_DAY_LO:  reg_rdata = day_v[7:0];
      ADR_DAY_HI:  reg_rdata = 8'(day_v >> 8);
      ADR_CMP_MIN: reg_rdata = cmp_min;
      ADR_CMP_HR:  reg_rdata = cmp_hr;
      ADR_CMP_DLO: reg_rdata = cmp_day[7:0];
      ADR_CMP_DHI: reg_rdata = 8'(cmp_day >> 8);
      default:     reg_rdata = 8'h00;
    endcase
  end

  assign alarm_irq = flag && cfg.irq_en;

  // R6: busy is visible only in a tick cycle
  a_r6_busy_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CTRL && reg_rdata[CB_BUSY]) |-> tick);

  // R5: without a counting tick or write the time holds
  a_r5_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_we) |=> ($stable(sec_v) && $stable(min_v) && $stable(hr_v) && $stable(day_v)));

  // R7: writes in a busy cycle leave the compare values untouched
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(cmp_min) && $stable(cmp_hr) && $stable(cmp_day)));

  // R9: the flag only rises after a counting tick
  a_r9_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy));

  // R10: with no compare enabled the flag stays clear
  a_r10_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.min_en && !cfg.hr_en && !cfg.day_en && !flag) |=> !flag);

  // R11: writing one to the flag bit clears it
  a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && reg_addr == ADR_CTRL && reg_wdata[CB_FLAG]) |=> !flag);

  // R12: the interrupt needs its enable
  a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> cfg.irq_en);
endmodule

// File: tb/sim_bcd_tod_alarm.sv
module sim_bcd_tod_alarm;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic alarm_irq;

  bcd_tod_alarm u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq));

  int total = 0, bad = 0;

  // Behavioural reference model
  int m_sec, m_min, m_hr, m_day;
  logic [7:0] m_amin, m_ahr, m_adlo, m_adhi;
  bit m_run, m_aie, m_men, m_hen, m_den, m_flag;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] a, bit bsy);
    case (a)
      8'h14: return {bsy, 1'b0, m_den, m_hen, m_men, m_flag, m_aie, m_run};
      8'h15: return to_bcd(m_sec);
      8'h16: return to_bcd(m_min);
      8'h17: return to_bcd(m_hr);
      8'h18: return 8'(m_day & 255);
      8'h19: return 8'(m_day >> 8);
      8'h1A: return m_amin;
      8'h1B: return m_ahr;
      8'h1C: return m_adlo;
      8'h1D: return m_adhi;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
      m_amin = 0; m_ahr = 0; m_adlo = 0; m_adhi = 0;
      m_run = 0; m_aie = 0; m_men = 0; m_hen = 0; m_den = 0; m_flag = 0;
    end else if (tick && m_run) begin
      m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hr++;
          if (m_hr == 24) begin m_hr = 0; m_day = (m_day + 1) % 32768; end
        end
        if ((m_men || m_hen || m_den) &&
            (!m_men || to_bcd(m_min) == m_amin) &&
            (!m_hen || to_bcd(m_hr) == m_ahr) &&
            (!m_den || m_day == ((int'(m_adhi) << 8) | int'(m_adlo))))
          m_flag = 1;
      end
    end else if (reg_we) begin
      case (reg_addr)
        8'h14: begin
          m_den = reg_wdata[5]; m_hen = reg_wdata[4]; m_men = reg_wdata[3];
          m_aie = reg_wdata[1]; m_run = reg_wdata[0];
          if (reg_wdata[2]) m_flag = 0;
        end
        8'h15: m_sec = from_bcd(reg_wdata);
        8'h16: m_min = from_bcd(reg_wdata);
        8'h17: m_hr  = from_bcd(reg_wdata);
        8'h18: m_day = (m_day & 32512) | int'(reg_wdata);
        8'h19: m_day = (m_day & 255) | (int'(reg_wdata & 8'h7F) << 8);
        8'h1A: m_amin = reg_wdata;
        8'h1B: m_ahr  = reg_wdata;
        8'h1C: m_adlo = reg_wdata;
        8'h1D: m_adhi = reg_wdata & 8'h7F;
        default: ;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: compare against the model, then drive the next inputs
  task automatic step(bit we, logic [7:0] a, logic [7:0] d, bit tk);
    logic [7:0] e;
    @(negedge clk);
    e = model_read(reg_addr, tick && m_run);
    chk(reg_rdata == e, "R8 model readback", int'(reg_rdata), int'(e));
    chk(alarm_irq == (m_flag && m_aie), "R12 model irq", int'(alarm_irq), int'(m_flag && m_aie));
    reg_we = we; reg_addr = a; reg_wdata = d; tick = tk;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(1, a, d, 0);
  endtask

  task automatic peek(logic [7:0] a, logic [7:0] exp, string tag);
    step(0, a, 8'h00, 0);
    #1;
    chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(8'h17, h); wr(8'h16, m); wr(8'h15, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    for (int a = 8'h14; a <= 8'h1D; a++) begin
      reg_addr = 8'(a);
      #1;
      chk(reg_rdata == 8'h00, "R1 reset value", int'(reg_rdata), 0);
    end
    chk(alarm_irq == 1'b0, "R1 reset irq", int'(alarm_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Full rollover from 23:59:58 day 0x7FFF
    set_time(8'h23, 8'h59, 8'h58);
    wr(8'h18, 8'hFF); wr(8'h19, 8'h7F); wr(8'h14, 8'h01);
    step(0, 8'h15, 0, 1);
    peek(8'h15, 8'h59, "R2 seconds step");
    step(0, 8'h15, 0, 1);
    peek(8'h15, 8'h00, "R2 seconds wrap");
    peek(8'h16, 8'h00, "R3 minute wrap");
    peek(8'h17, 8'h00, "R3 hour wrap");
    peek(8'h18, 8'h00, "R4 day low wrap");
    peek(8'h19, 8'h00, "R4 day high wrap");

    // Ticks with run cleared
    wr(8'h14, 8'h00);
    step(0, 8'h15, 0, 1); step(0, 8'h15, 0, 1); step(0, 8'h14, 0, 1);
    #1; chk(reg_rdata == 8'h00, "R6 no busy when stopped", int'(reg_rdata), 0);
    peek(8'h15, 8'h00, "R5 hold while stopped");

    // Busy and dropped writes
    wr(8'h14, 8'h01);
    step(0, 8'h14, 0, 1);
    #1; chk(reg_rdata == 8'h81, "R6 busy in tick cycle", int'(reg_rdata), 32'h81);
    step(1, 8'h1A, 8'h33, 1);
    peek(8'h1A, 8'h00, "R7 compare write dropped");
    step(1, 8'h15, 8'h40, 1);
    peek(8'h15, 8'h03, "R7 seconds write dropped");

    // Hour carry into day byte boundary
    set_time(8'h23, 8'h59, 8'h59);
    wr(8'h18, 8'hFF); wr(8'h19, 8'h00);
    step(0, 8'h15, 0, 1);
    peek(8'h18, 8'h00, "R4 day low after carry");
    peek(8'h19, 8'h01, "R4 day high after carry");

    // Minute alarm
    wr(8'h1A, 8'h01);
    set_time(8'h00, 8'h00, 8'h59);
    wr(8'h14, 8'h0B);
    step(0, 8'h14, 0, 1);
    peek(8'h14, 8'h0F, "R9 minute match sets flag");
    chk(alarm_irq == 1'b1, "R12 irq with enable", int'(alarm_irq), 1);
    wr(8'h14, 8'h0B);
    peek(8'h14, 8'h0F, "R11 zero leaves flag");
    wr(8'h14, 8'h09);
    peek(8'h14, 8'h0D, "R12 irq enable off");
    chk(alarm_irq == 1'b0, "R12 irq masked", int'(alarm_irq), 0);
    wr(8'h14, 8'h0D);
    peek(8'h14, 8'h09, "R11 one clears flag");

    // Hour mismatch blocks, then match
    wr(8'h1B, 8'h05);
    set_time(8'h00, 8'h00, 8'h59);
    wr(8'h14, 8'h1B);
    step(0, 8'h15, 0, 1);
    peek(8'h14, 8'h1B, "R9 hour mismatch");
    wr(8'h1B, 8'h00);
    set_time(8'h00, 8'h00, 8'h59);
    step(0, 8'h15, 0, 1);
    peek(8'h14, 8'h1F, "R9 minute and hour match");
    wr(8'h14, 8'h1F);

    // Day alone; minute and hour are not compared
    wr(8'h1C, 8'h00); wr(8'h1D, 8'h01);
    wr(8'h14, 8'h23);
    set_time(8'h12, 8'h34, 8'h59);
    step(0, 8'h15, 0, 1);
    peek(8'h14, 8'h27, "R9 day match alone");
    peek(8'h1D, 8'h01, "R8 compare day high readback");
    wr(8'h14, 8'h27);

    // No enables
    wr(8'h14, 8'h03);
    set_time(8'h00, 8'h00, 8'h59);
    step(0, 8'h15, 0, 1);
    peek(8'h14, 8'h03, "R10 no enables no flag");
    chk(alarm_irq == 1'b0, "R10 irq stays low", int'(alarm_irq), 0);

    // Unmapped addresses
    peek(8'h13, 8'h00, "R8 unmapped below");
    peek(8'h20, 8'h00, "R8 unmapped above");

    // Long run against the model
    wr(8'h1A, 8'h02); wr(8'h14, 8'h0B);
    set_time(8'h23, 8'h58, 8'h30);
    for (int i = 0; i < 400; i++)
      step(0, 8'(8'h14 + (i % 10)), 8'h00, (i % 3) != 0);
    peek(8'h17, 8'h00, "R3 long run hour");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule